// File: doc/BRIEF.md
# UART FIFO Pair with Programmable Request Thresholds

This block holds the two byte queues of a UART: one toward the transmitter and one from the receiver. Each queue is 64 entries deep and is reached through plain push and pop strobes, with the head entry always visible on its read-data port. Each direction raises a level-sensitive request that can serve as an interrupt or a DMA request. The transmit request reflects free room in the transmit queue. The receive request reflects how many bytes are waiting in the receive queue.

The threshold for each direction comes from three small configuration registers written through a byte-wide port. A 2-bit coarse code selects one of four preset levels, and that preset table differs between the two directions. A 4-bit trigger field gives multiples of four. A per-direction fine-step bit joins the two fields into one 6-bit level. Serial shifting, baud timing and line status belong to neighbouring blocks.

Top module: `uart_fifo_trig`

## Requirements
- R1: A synchronous reset empties both queues and clears every configuration field to zero. Straight after reset, tx_empty and rx_empty are 1, tx_full, rx_full and all four error pulses are 0, tx_req is 1 and rx_req is 0.
- R2: Configuration writes are decoded as follows. Address 0 carries the coarse codes: bits [1:0] for TX and bits [3:2] for RX. Address 1 carries the trigger fields: bits [3:0] for TX and bits [7:4] for RX. Address 2 carries the fine-step bits: bit 0 for TX and bit 1 for RX. Address 3 is ignored. For TX, when the fine bit is 0 and the TX trigger field is 0, coarse codes 0, 1, 2 and 3 give thresholds of 8, 16, 32 and 56 free entries.
- R3: For RX, when the fine bit is 0 and the RX trigger field is 0, coarse codes 0, 1, 2 and 3 give thresholds of 8, 16, 56 and 60 stored bytes.
- R4: When the fine bit is 0 and the trigger field is non-zero, the threshold is four times the trigger field (4 to 60).
- R5: When the fine bit is 1, the threshold is the trigger field taken as the upper four bits and the coarse code as the lower two bits (1 to 63).
- R6: A fine-mode threshold that evaluates to zero is treated as 1.
- R7: tx_req is 1 exactly while the free entries (64 minus TX occupancy) are at or above the TX threshold. rx_req is 1 exactly while the RX occupancy is at or above the RX threshold. Both follow the queue state in the same cycle.
- R8: The TX and RX fine bits act independently, so the two directions may use different threshold modes at once.
- R9: Each queue returns bytes in push order. The head is shown on its read-data port while the queue is not empty. The full flag is 1 at 64 entries and the empty flag is 1 at 0 entries.
- R10: A push into a full queue is dropped, and that queue's overflow output is 1 for exactly the one cycle after the push edge.
- R11: A pop from an empty queue is ignored, and that queue's underflow output is 1 for exactly the one cycle after the pop edge.
- R12: A configuration write changes the request outputs from the clock edge that captures it, not before, and leaves queue contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| tx_push | input | 1 | Push tx_wdata into the TX queue |
| tx_wdata | input | 8 | TX push data |
| tx_pop | input | 1 | Remove the TX head |
| tx_rdata | output | 8 | TX head entry |
| tx_full | output | 1 | TX queue holds 64 entries |
| tx_empty | output | 1 | TX queue holds no entry |
| tx_ovf | output | 1 | Dropped TX push, one-cycle pulse |
| tx_udf | output | 1 | Ignored TX pop, one-cycle pulse |
| tx_req | output | 1 | TX free-room request |
| rx_push | input | 1 | Push rx_wdata into the RX queue |
| rx_wdata | input | 8 | RX push data |
| rx_pop | input | 1 | Remove the RX head |
| rx_rdata | output | 8 | RX head entry |
| rx_full | output | 1 | RX queue holds 64 entries |
| rx_empty | output | 1 | RX queue holds no entry |
| rx_ovf | output | 1 | Dropped RX push, one-cycle pulse |
| rx_udf | output | 1 | Ignored RX pop, one-cycle pulse |
| rx_req | output | 1 | RX fill-level request |

## Verification
A corrupted occupancy counter shows up at once on the full and empty flags and on the request outputs. This is why the bench sweeps each configuration through every fill level from 0 to 64 and back, comparing both requests at every step. A bad pointer shows up later, when a wrong byte reaches the head. The scoreboard catches it on the pop that exposes the byte. A wrong threshold decode shifts the request edge by at least one entry, and the sweep catches it on the same step.

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          tx_ovf,
  output logic          tx_udf,
  output logic          tx_req,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          rx_ovf,
  output logic          rx_udf,
  output logic          rx_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0] crs_tx, crs_rx;
  logic [3:0] trg_tx, trg_rx;
  logic       fin_tx, fin_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_tx <= '0; crs_rx <= '0;
      trg_tx <= '0; trg_rx <= '0;
      fin_tx <= 1'b0; fin_rx <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin crs_tx <= cfg_wdata[1:0]; crs_rx <= cfg_wdata[3:2]; end
        2'd1: begin trg_tx <= cfg_wdata[3:0]; trg_rx <= cfg_wdata[7:4]; end
        2'd2: begin fin_tx <= cfg_wdata[0];   fin_rx <= cfg_wdata[1];   end
        default: ;
      endcase
    end
  end

  function automatic logic [5:0] level(input logic fine, input logic [3:0] trg,
                                       input logic [1:0] crs, input logic is_rx);
    logic [5:0] v;
    if (fine) begin
      v = {trg, crs};
      if (v == 6'd0) v = 6'd1;
    end else if (trg != 4'd0) begin
      v = {trg, 2'b00};
    end else begin
      case (crs)
        2'd0: v = 6'd8;
        2'd1: v = 6'd16;
        2'd2: v = is_rx ? 6'd56 : 6'd32;
        default: v = is_rx ? 6'd60 : 6'd56;
      endcase
    end
    return v;
  endfunction

  logic [5:0] thr_tx, thr_rx;
  assign thr_tx = level(fin_tx, trg_tx, crs_tx, 1'b0);
  assign thr_rx = level(fin_rx, trg_rx, crs_rx, 1'b1);

  logic [1:0]    push_v, pop_v, full_v, empty_v, ovf_v, udf_v;
  logic [DW-1:0] wd_v [2];
  logic [DW-1:0] rd_v [2];
  logic [CW-1:0] cnt_v [2];

  assign push_v = {rx_push, tx_push};
  assign pop_v  = {rx_pop, tx_pop};
  assign wd_v[0] = tx_wdata;
  assign wd_v[1] = rx_wdata;

  for (genvar g = 0; g < 2; g++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          ovf, udf, do_w, do_r;

    assign do_w = push_v[g] && (cnt != CW'(DEPTH));
    assign do_r = pop_v[g] && (cnt != '0);

    always_ff @(posedge clk) begin
      if (do_w) mem[wp] <= wd_v[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0; udf <= 1'b0;
      end else begin
        if (do_w) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (do_r) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(do_w) - CW'(do_r);
        ovf <= push_v[g] && !do_w;
        udf <= pop_v[g] && !do_r;
      end
    end

    assign rd_v[g]    = mem[rp];
    assign cnt_v[g]   = cnt;
    assign full_v[g]  = (cnt == CW'(DEPTH));
    assign empty_v[g] = (cnt == '0);
    assign ovf_v[g]   = ovf;
    assign udf_v[g]   = udf;

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(DEPTH));
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
      (push_v[g] && full_v[g] && !pop_v[g]) |=> (full_v[g] && ovf_v[g]));
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
      (pop_v[g] && empty_v[g] && !push_v[g]) |=> (empty_v[g] && udf_v[g]));
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
      !(full_v[g] && empty_v[g]));
  end

  assign tx_rdata = rd_v[0];
  assign rx_rdata = rd_v[1];
  assign tx_full  = full_v[0];
  assign rx_full  = full_v[1];
  assign tx_empty = empty_v[0];
  assign rx_empty = empty_v[1];
  assign tx_ovf   = ovf_v[0];
  assign rx_ovf   = ovf_v[1];
  assign tx_udf   = udf_v[0];
  assign rx_udf   = udf_v[1];

  assign tx_req = (CW'(DEPTH) - cnt_v[0]) >= CW'(thr_tx);
  assign rx_req = cnt_v[1] >= CW'(thr_rx);

  p_tx_empty_req_r7: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_req);
  p_rx_full_req_r7: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> rx_req);
  p_rx_empty_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> !rx_req);
endmodule

// File: tb/uart_fifo_trig_bench.sv
`timescale 1ns/1ps
module uart_fifo_trig_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic tx_full, tx_empty, tx_ovf, tx_udf, tx_req;
  logic rx_full, rx_empty, rx_ovf, rx_udf, rx_req;

  uart_fifo_trig u_uart_fifo_trig (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovf(tx_ovf), .tx_udf(tx_udf), .tx_req(tx_req),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovf(rx_ovf), .rx_udf(rx_udf), .rx_req(rx_req));

  always #4 clk = ~clk;

  int runs = 0, fails = 0;
  int mtx = 0, mrx = 0;
  logic [7:0] seed = 8'h11;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  task automatic chk(string r, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && tx_pop && !tx_empty) begin
      if (txq.size() == 0) chk("R9 tx extra data", 1, 0);
      else chk("R9 tx order", int'(tx_rdata), int'(txq.pop_front()));
    end
    if (!rst && rx_pop && !rx_empty) begin
      if (rxq.size() == 0) chk("R9 rx extra data", 1, 0);
      else chk("R9 rx order", int'(rx_rdata), int'(rxq.pop_front()));
    end
  end

  task automatic step(input bit ptx, input bit prx, input bit otx, input bit orx);
    @(posedge clk); #1;
    tx_push = ptx; rx_push = prx; tx_pop = otx; rx_pop = orx;
    tx_wdata = seed; rx_wdata = ~seed;
    if (ptx && mtx < 64) txq.push_back(seed);
    if (prx && mrx < 64) rxq.push_back(~seed);
    mtx = mtx + ((ptx && mtx < 64) ? 1 : 0) - ((otx && mtx > 0) ? 1 : 0);
    mrx = mrx + ((prx && mrx < 64) ? 1 : 0) - ((orx && mrx > 0) ? 1 : 0);
    @(posedge clk); #1;
    tx_push = 0; rx_push = 0; tx_pop = 0; rx_pop = 0;
    seed = seed + 8'd37;
    #1;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic sweep(string r, int tt, int rt);
    #1;
    for (int i = 0; i <= 64; i++) begin
      chk({r, " tx_req"}, int'(tx_req), int'((64 - i) >= tt));
      chk({r, " rx_req"}, int'(rx_req), int'(i >= rt));
      chk("R9 full", int'(tx_full), int'(i == 64));
      if (i < 64) step(1, 1, 0, 0);
    end
    for (int i = 63; i >= 0; i--) begin
      step(0, 0, 1, 1);
      chk({r, " tx_req drain"}, int'(tx_req), int'((64 - i) >= tt));
      chk({r, " rx_req drain"}, int'(rx_req), int'(i >= rt));
      chk("R9 empty", int'(rx_empty), int'(i == 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #2;
    chk("R1 tx_empty", int'(tx_empty), 1);
    chk("R1 rx_empty", int'(rx_empty), 1);
    chk("R1 full", int'(tx_full | rx_full), 0);
    chk("R1 pulses", int'(tx_ovf | tx_udf | rx_ovf | rx_udf), 0);
    chk("R1 tx_req", int'(tx_req), 1);
    chk("R1 rx_req", int'(rx_req), 0);

    sweep("R1 R7 default", 8, 8);
    cfg(2'd0, 8'b0000_1011); sweep("R2 R3 codes 3/2", 56, 56);
    cfg(2'd0, 8'b0000_1110); sweep("R2 R3 codes 2/3", 32, 60);
    cfg(2'd0, 8'b0000_0101); sweep("R2 R3 codes 1/1", 16, 16);
    cfg(2'd3, 8'hFF);        sweep("R2 addr3 ignored", 16, 16);
    cfg(2'd0, 8'h00);
    cfg(2'd1, 8'hF5);        sweep("R4 steps", 20, 60);
    cfg(2'd1, 8'h10);        sweep("R4 low step", 8, 4);
    cfg(2'd2, 8'h03);
    cfg(2'd0, 8'b0000_1101);
    cfg(2'd1, 8'hFA);        sweep("R5 fine", 41, 63);
    cfg(2'd0, 8'h00);
    cfg(2'd1, 8'h00);        sweep("R6 clamp", 1, 1);
    cfg(2'd2, 8'h01);
    cfg(2'd0, 8'b0000_0011);
    cfg(2'd1, 8'h32);        sweep("R8 mixed", 11, 12);

    cfg(2'd2, 8'h00); cfg(2'd1, 8'h00); cfg(2'd0, 8'h00);
    for (int i = 0; i < 64; i++) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R10 tx_ovf pulse", int'(tx_ovf), 1);
    chk("R10 tx_full", int'(tx_full), 1);
    step(0, 0, 0, 0);
    chk("R10 tx_ovf drop", int'(tx_ovf), 0);
    for (int i = 0; i < 64; i++) step(0, 0, 1, 0);
    chk("R10 dropped byte absent", int'(tx_empty), 1);
    step(0, 0, 1, 0);
    chk("R11 tx_udf pulse", int'(tx_udf), 1);
    chk("R11 tx stays empty", int'(tx_empty), 1);
    step(0, 0, 0, 0);
    chk("R11 tx_udf drop", int'(tx_udf), 0);
    step(0, 0, 0, 1);
    chk("R11 rx_udf pulse", int'(rx_udf), 1);
    step(0, 0, 0, 0);
    chk("R11 rx_udf drop", int'(rx_udf), 0);
    for (int i = 0; i < 64; i++) step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    chk("R10 rx_ovf pulse", int'(rx_ovf), 1);
    for (int i = 0; i < 54; i++) step(0, 0, 0, 1);

    chk("R12 rx_req before", int'(rx_req), 1);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 2'd1; cfg_wdata = 8'h30;
    @(negedge clk);
    chk("R12 rx_req unchanged before edge", int'(rx_req), 1);
    @(posedge clk); #1;
    cfg_we = 0;
    #1;
    chk("R12 rx_req after edge", int'(rx_req), 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1);
    chk("R12 rx drained", int'(rx_empty), 1);
    chk("R9 queues consumed", txq.size() + rxq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule